// File: doc/BRIEF.md
# Streaming 16-Point Complex FFT Core

This block computes the forward discrete Fourier transform of a 16-sample complex frame in fixed point. Samples arrive and results leave on valid/ready stream channels. A one-byte configuration word arms the core. The core then takes exactly sixteen input words and stores each one at its bit-reversed address. It runs the four radix-2 decimation-in-time stages with one butterfly per clock. Finally it returns sixteen bins in natural order, and the last bin carries the end-of-frame marker.

The result is not scaled by 1/N. Each result is held in a 32-bit accumulator and leaves the core as a 16-bit value that saturates instead of wrapping. The twiddle factors come from a four-entry quarter-wave cosine table that is computed when the design elaborates. Every sine value and every other quadrant is folded out of that table with index arithmetic and sign changes. The configuration channel is open only while the core is idle. To start the next frame, the user writes a new configuration after the previous results have drained.

Top module: `fft16_stream_core`

## Requirements
- R1: After an active-low synchronous reset, `cfg_tready` is 1 and both `s_tready` and `m_tvalid` are 0.
- R2: `cfg_tready` is high only while idle, and at most one of `cfg_tready`, `s_tready` and `m_tvalid` is high in any cycle. An accepted config byte with bit 0 = 1 opens sample intake. A byte with bit 0 = 0 is consumed and the core stays idle. Bits [7:1] are reserved and are written as zero.
- R3: Each 32-bit word, both input and output, carries the imaginary part in bits [31:16] and the real part in bits [15:0], each as 16-bit two's complement.
- R4: Intake takes exactly 16 samples and stalls while `s_tvalid` is low. `s_tlast` accompanies the 16th sample. `s_tready` is low after the 16th sample.
- R5: Output bin k equals the sum over n of x[n]·e^(−j2πkn/16), with no 1/N factor, within ±6 LSB of the exactly rounded value, in natural order k = 0..15.
- R6: An impulse of amplitude A at index 0 yields A+j0 in every bin within ±3 LSB. A constant input A (|A| ≤ 2047, per part) yields exactly 16·A in bin 0 and values within ±4 LSB of zero elsewhere.
- R7: An all-zero frame yields exactly zero in every bin.
- R8: A bin whose exact value exceeds the 16-bit range leaves the core as +32767 or −32768.
- R9: Exactly 16 words are emitted per frame, and `m_tlast` is high on the 16th word only. After that word the core is idle, with `cfg_tready` = 1 and `m_tvalid` = 0.
- R10: While `m_tvalid` is high and `m_tready` is low, `m_tvalid`, `m_tdata` and `m_tlast` hold their values into the next cycle, and no bin is lost.
- R11: A frame's results do not depend on any earlier frame.
- R12: A reset during intake or during output returns the core to idle and drops `m_tvalid`. The next frame is then correct.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_tdata | input | 8 | Config byte; bit 0 = 1 arms a forward transform |
| cfg_tvalid | input | 1 | Config word valid |
| cfg_tready | output | 1 | Config accepted (idle only) |
| s_tdata | input | 32 | Input sample {imag, real} |
| s_tvalid | input | 1 | Input sample valid |
| s_tlast | input | 1 | Marks the 16th input sample |
| s_tready | output | 1 | Core accepts a sample |
| m_tdata | output | 32 | Output bin {imag, real}, saturated |
| m_tvalid | output | 1 | Output bin valid |
| m_tlast | output | 1 | Marks bin 15 |
| m_tready | input | 1 | Downstream accepts the bin |

## Verification
The bench sweeps a unit-spaced impulse across all sixteen input positions. This exposes bit-reversal and twiddle-folding errors, because every position produces a different phase ramp across the bins. Constant frames isolate the bin-0 path, which must be exact, and a large constant drives that bin into saturation. A complex exponential and a real cosine confirm that the peak lands in the right bin with the right sign on the imaginary part. Pseudo-random frames, run with input gaps and output back-pressure and followed at once by an all-zero frame, show that stalls neither corrupt data nor carry state into the next frame.

// File: rtl/fft16_pkg.sv
`timescale 1ns/1ps
package fft16_pkg;

    // Core phase: configuration wait, sample intake, butterfly passes, result drain
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_LOAD = 2'd1,
        PH_CALC = 2'd2,
        PH_EMIT = 2'd3
    } fft_phase_e;

endpackage

// File: rtl/fft16_twiddle.sv
`timescale 1ns/1ps
// Twiddle source: quarter-wave cosine table built at elaboration,
// folded into cos/sin over [0, pi) for index k in 0..N/2-1.
module fft16_twiddle #(
    parameter int N_PTS = 16,
    parameter int TW_W  = 16
) (
    input  logic [$clog2(N_PTS)-2:0] k_i,
    output logic signed [TW_W-1:0]   cos_o,
    output logic signed [TW_W-1:0]   sin_o
);
    localparam int QTR = N_PTS / 4;
    localparam int QW  = (QTR > 1) ? $clog2(QTR) : 1;

    typedef logic [QTR-1:0][TW_W-1:0] qtab_t;

    function automatic real cos_series(input real x);
        real term;
        real acc;
        term = 1.0;
        acc  = 1.0;
        for (int i = 1; i <= 12; i++) begin
            term = -term * x * x / real'((2 * i - 1) * (2 * i));
            acc  = acc + term;
        end
        return acc;
    endfunction

    function automatic qtab_t build_qtab();
        qtab_t t;
        real   v;
        int    r;
        int    top;
        top = (1 << (TW_W - 1)) - 1;
        for (int k = 0; k < QTR; k++) begin
            v = cos_series(2.0 * 3.14159265358979 * real'(k) / real'(N_PTS)) * real'(top);
            r = $rtoi(v + 0.5);
            if (r > top) r = top;
            t[k] = TW_W'(r);
        end
        return t;
    endfunction

    localparam qtab_t QTAB = build_qtab();

    always_comb begin
        int k;
        int m;
        k = int'(k_i);
        // cos over [0, pi): first quadrant direct, second by mirror and negate
        if (k < QTR)       cos_o = signed'(QTAB[QW'(k)]);
        else if (k == QTR) cos_o = '0;
        else               cos_o = -signed'(QTAB[QW'(N_PTS / 2 - k)]);
        // sin(theta) = cos(pi/2 - theta), distance from the quarter point
        m = (k <= QTR) ? (QTR - k) : (k - QTR);
        if (m >= QTR) sin_o = '0;
        else          sin_o = signed'(QTAB[QW'(m)]);
    end

    // A unit-magnitude twiddle can never fold to zero in both parts
    always_comb begin
        assert_twiddle_unit_R5: assert (cos_o != '0 || sin_o != '0);
    end

endmodule

// File: rtl/fft16_butterfly.sv
`timescale 1ns/1ps
// Radix-2 DIT butterfly: y0 = a + W*b, y1 = a - W*b, W = cos - j*sin.
// Twiddle product rounded to nearest after the Q(TW_W-1) shift.
module fft16_butterfly #(
    parameter int ACC_W = 32,
    parameter int TW_W  = 16
) (
    input  logic signed [ACC_W-1:0] a_re,
    input  logic signed [ACC_W-1:0] a_im,
    input  logic signed [ACC_W-1:0] b_re,
    input  logic signed [ACC_W-1:0] b_im,
    input  logic signed [TW_W-1:0]  w_cos,
    input  logic signed [TW_W-1:0]  w_sin,
    output logic signed [ACC_W-1:0] y0_re,
    output logic signed [ACC_W-1:0] y0_im,
    output logic signed [ACC_W-1:0] y1_re,
    output logic signed [ACC_W-1:0] y1_im
);
    localparam int PW = ACC_W + TW_W + 1;
    localparam int SH = TW_W - 1;
    localparam logic signed [PW-1:0] RND = PW'(1) <<< (SH - 1);

    logic signed [PW-1:0]    t_re_d, t_im_d;
    logic signed [PW-1:0]    t_re_sh, t_im_sh;
    logic signed [ACC_W-1:0] t_re, t_im;

    always_comb begin
        t_re_d  = PW'(b_re) * PW'(w_cos) + PW'(b_im) * PW'(w_sin);
        t_im_d  = PW'(b_im) * PW'(w_cos) - PW'(b_re) * PW'(w_sin);
        t_re_sh = (t_re_d + RND) >>> SH;
        t_im_sh = (t_im_d + RND) >>> SH;
        t_re    = ACC_W'(t_re_sh);
        t_im    = ACC_W'(t_im_sh);
        y0_re   = a_re + t_re;
        y0_im   = a_im + t_im;
        y1_re   = a_re - t_re;
        y1_im   = a_im - t_im;
    end

    // Zero operands must give exactly zero: rounding may not bias
    always_comb begin
        if (a_re == '0 && a_im == '0 && b_re == '0 && b_im == '0) begin
            assert_zero_in_zero_out_R7: assert (y0_re == '0 && y0_im == '0 && y1_re == '0 && y1_im == '0);
        end
    end

endmodule

// File: rtl/fft16_stream_core.sv
`timescale 1ns/1ps
module fft16_stream_core
    import fft16_pkg::*;
#(
    parameter int N_PTS    = 16,
    parameter int SAMPLE_W = 16,
    parameter int ACC_W    = 32,
    parameter int TW_W     = 16,
    parameter int CFG_W    = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [CFG_W-1:0]      cfg_tdata,
    input  logic                  cfg_tvalid,
    output logic                  cfg_tready,
    input  logic [2*SAMPLE_W-1:0] s_tdata,
    input  logic                  s_tvalid,
    input  logic                  s_tlast,
    output logic                  s_tready,
    output logic [2*SAMPLE_W-1:0] m_tdata,
    output logic                  m_tvalid,
    output logic                  m_tlast,
    input  logic                  m_tready
);
    localparam int LOG2N = $clog2(N_PTS);
    localparam int STG_W = (LOG2N > 1) ? $clog2(LOG2N) : 1;
    localparam int BF_W  = LOG2N - 1;
    localparam logic [LOG2N-1:0] LAST_IDX  = LOG2N'(N_PTS - 1);
    localparam logic [STG_W-1:0] LAST_STG  = STG_W'(LOG2N - 1);
    localparam logic [BF_W-1:0]  LAST_BF   = BF_W'(N_PTS / 2 - 1);
    localparam logic signed [ACC_W-1:0] OUT_HI = ACC_W'((1 << (SAMPLE_W - 1)) - 1);
    localparam logic signed [ACC_W-1:0] OUT_LO = ACC_W'(-(1 << (SAMPLE_W - 1)));

    typedef struct packed {
        fft_phase_e                   ph;
        logic [LOG2N-1:0]             idx;
        logic [STG_W-1:0]             stage;
        logic [BF_W-1:0]              bfly;
        logic [N_PTS-1:0][ACC_W-1:0]  re;
        logic [N_PTS-1:0][ACC_W-1:0]  im;
    } core_st_t;

    core_st_t st_q, st_d;

    function automatic logic [LOG2N-1:0] bit_rev(input logic [LOG2N-1:0] v);
        logic [LOG2N-1:0] r;
        for (int b = 0; b < LOG2N; b++) r[b] = v[LOG2N-1-b];
        return r;
    endfunction

    function automatic logic [SAMPLE_W-1:0] clamp_out(input logic signed [ACC_W-1:0] v);
        if (v > OUT_HI) return OUT_HI[SAMPLE_W-1:0];
        if (v < OUT_LO) return OUT_LO[SAMPLE_W-1:0];
        return v[SAMPLE_W-1:0];
    endfunction

    // Butterfly addressing for the current stage and butterfly counter
    logic [LOG2N-1:0] top_idx, bot_idx;
    logic [BF_W-1:0]  tw_k;

    always_comb begin
        int span;
        int pos;
        int grp;
        span    = 1 << int'(st_q.stage);
        pos     = int'(st_q.bfly) & (span - 1);
        grp     = int'(st_q.bfly) >> int'(st_q.stage);
        top_idx = LOG2N'(grp * 2 * span + pos);
        bot_idx = LOG2N'(grp * 2 * span + pos + span);
        tw_k    = BF_W'(pos << (LOG2N - 1 - int'(st_q.stage)));
    end

    logic signed [TW_W-1:0]  w_cos, w_sin;
    logic signed [ACC_W-1:0] y0_re, y0_im, y1_re, y1_im;

    fft16_twiddle #(
        .N_PTS (N_PTS),
        .TW_W  (TW_W)
    ) u_twiddle (
        .k_i   (tw_k),
        .cos_o (w_cos),
        .sin_o (w_sin)
    );

    fft16_butterfly #(
        .ACC_W (ACC_W),
        .TW_W  (TW_W)
    ) u_butterfly (
        .a_re  ($signed(st_q.re[top_idx])),
        .a_im  ($signed(st_q.im[top_idx])),
        .b_re  ($signed(st_q.re[bot_idx])),
        .b_im  ($signed(st_q.im[bot_idx])),
        .w_cos (w_cos),
        .w_sin (w_sin),
        .y0_re (y0_re),
        .y0_im (y0_im),
        .y1_re (y1_re),
        .y1_im (y1_im)
    );

    always_comb begin
        st_d = st_q;
        unique case (st_q.ph)
            PH_IDLE: begin
                if (cfg_tvalid && cfg_tdata[0]) begin
                    st_d.ph  = PH_LOAD;
                    st_d.idx = '0;
                end
            end
            PH_LOAD: begin
                if (s_tvalid) begin
                    st_d.re[bit_rev(st_q.idx)] = ACC_W'(signed'(s_tdata[SAMPLE_W-1:0]));
                    st_d.im[bit_rev(st_q.idx)] = ACC_W'(signed'(s_tdata[2*SAMPLE_W-1:SAMPLE_W]));
                    st_d.idx = st_q.idx + 1'b1;
                    if (st_q.idx == LAST_IDX) begin
                        st_d.ph    = PH_CALC;
                        st_d.stage = '0;
                        st_d.bfly  = '0;
                    end
                end
            end
            PH_CALC: begin
                st_d.re[top_idx] = y0_re;
                st_d.im[top_idx] = y0_im;
                st_d.re[bot_idx] = y1_re;
                st_d.im[bot_idx] = y1_im;
                st_d.bfly = st_q.bfly + 1'b1;
                if (st_q.bfly == LAST_BF) begin
                    if (st_q.stage == LAST_STG) begin
                        st_d.ph  = PH_EMIT;
                        st_d.idx = '0;
                    end else begin
                        st_d.stage = st_q.stage + 1'b1;
                    end
                end
            end
            PH_EMIT: begin
                if (m_tready) begin
                    st_d.idx = st_q.idx + 1'b1;
                    if (st_q.idx == LAST_IDX) st_d.ph = PH_IDLE;
                end
            end
            default: st_d.ph = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cfg_tready = (st_q.ph == PH_IDLE);
    assign s_tready   = (st_q.ph == PH_LOAD);
    assign m_tvalid   = (st_q.ph == PH_EMIT);
    assign m_tlast    = m_tvalid && (st_q.idx == LAST_IDX);
    assign m_tdata    = {clamp_out($signed(st_q.im[st_q.idx])), clamp_out($signed(st_q.re[st_q.idx]))};

    // Reset leaves the core idle with no channel but config open
    assert_reset_idle_R1: assert property (@(posedge clk)
        !rst_n |=> (cfg_tready && !s_tready && !m_tvalid));

    assert_one_channel_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({cfg_tready, s_tready, m_tvalid}));

    assert_cfg_reserved_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_tvalid && cfg_tready) |-> (cfg_tdata[CFG_W-1:1] == '0));

    // The frame marker from upstream must coincide with the 16th accepted sample
    assert_in_last_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (s_tvalid && s_tready) |-> (s_tlast == (st_q.idx == LAST_IDX)));

    assert_out_last_R9: assert property (@(posedge clk) disable iff (!rst_n)
        m_tlast |-> m_tvalid);

    assert_out_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (m_tvalid && !m_tready) |=> (m_tvalid && $stable(m_tdata) && $stable(m_tlast)));

endmodule

// File: tb/fft16_stream_core_tb.sv
`timescale 1ns/1ps
module fft16_stream_core_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  cfg_tdata = '0;
    logic        cfg_tvalid = 1'b0;
    logic        cfg_tready;
    logic [31:0] s_tdata = '0;
    logic        s_tvalid = 1'b0;
    logic        s_tlast = 1'b0;
    logic        s_tready;
    logic [31:0] m_tdata;
    logic        m_tvalid;
    logic        m_tlast;
    logic        m_tready = 1'b1;

    always #2.5 clk = ~clk;

    fft16_stream_core u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_tdata  (cfg_tdata),
        .cfg_tvalid (cfg_tvalid),
        .cfg_tready (cfg_tready),
        .s_tdata    (s_tdata),
        .s_tvalid   (s_tvalid),
        .s_tlast    (s_tlast),
        .s_tready   (s_tready),
        .m_tdata    (m_tdata),
        .m_tvalid   (m_tvalid),
        .m_tlast    (m_tlast),
        .m_tready   (m_tready)
    );

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    int in_re [16];
    int in_im [16];
    int exp_re[16];
    int exp_im[16];
    int got_re[16];
    int got_im[16];
    int got_n, last_pos, tlast_cnt;
    int unsigned seed = 32'h1234_5678;

    task automatic chk(input string tag, input string what, input int act, input int exp, input int tol);
        int d;
        checks++;
        d = act - exp;
        if (d < 0) d = -d;
        if (d > tol) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    function automatic int rnd_sat(input real v);
        int r;
        r = (v >= 0.0) ? $rtoi(v + 0.5) : -$rtoi(-v + 0.5);
        if (r > 32767) r = 32767;
        if (r < -32768) r = -32768;
        return r;
    endfunction

    // Exact DFT of the integer inputs, rounded and clamped to 16 bits
    task automatic ref_dft();
        real sr, si, a;
        for (int k = 0; k < 16; k++) begin
            sr = 0.0;
            si = 0.0;
            for (int n = 0; n < 16; n++) begin
                a  = 2.0 * 3.14159265358979 * real'(k * n) / 16.0;
                sr = sr + real'(in_re[n]) * $cos(a) + real'(in_im[n]) * $sin(a);
                si = si + real'(in_im[n]) * $cos(a) - real'(in_re[n]) * $sin(a);
            end
            exp_re[k] = rnd_sat(sr);
            exp_im[k] = rnd_sat(si);
        end
    endtask

    task automatic send_cfg(input logic [7:0] b);
        @(negedge clk);
        while (!cfg_tready) @(negedge clk);
        cfg_tdata  = b;
        cfg_tvalid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        cfg_tvalid = 1'b0;
        cfg_tdata  = '0;
        chk("R2", "intake open after config", int'(s_tready), int'(b[0]), 0);
        chk("R2", "config ready after config", int'(cfg_tready), int'(!b[0]), 0);
    endtask

    task automatic feed(input bit gaps, input int cnt);
        int  n;
        int  c;
        bit  rdy;
        n = 0;
        c = 0;
        while (n < cnt) begin
            @(negedge clk);
            c++;
            s_tvalid = !(gaps && (c % 4 == 2));
            s_tdata  = {16'(in_im[n]), 16'(in_re[n])};
            s_tlast  = (n == 15);
            rdy      = s_tready;
            @(posedge clk);
            if (s_tvalid && rdy) n++;
        end
        @(negedge clk);
        s_tvalid = 1'b0;
        s_tlast  = 1'b0;
        if (cnt == 16) chk("R4", "intake closed after 16 samples", int'(s_tready), 0, 0);
    endtask

    task automatic drain(input bit bp);
        int          cyc;
        bit          held;
        logic [31:0] prev;
        got_n = 0; last_pos = -1; tlast_cnt = 0; cyc = 0; held = 1'b0; prev = '0;
        while (got_n < 16) begin
            @(negedge clk);
            m_tready = bp ? (cyc % 3 != 0) : 1'b1;
            cyc++;
            if (held) begin
                chk("R10", "valid held under back-pressure", int'(m_tvalid), 1, 0);
                chk("R10", "data held under back-pressure", int'(m_tdata == prev), 1, 0);
            end
            held = 1'b0;
            if (m_tvalid) begin
                if (m_tready) begin
                    got_re[got_n] = int'($signed(m_tdata[15:0]));
                    got_im[got_n] = int'($signed(m_tdata[31:16]));
                    if (m_tlast) begin
                        tlast_cnt++;
                        last_pos = got_n;
                    end
                    got_n++;
                end else begin
                    held = 1'b1;
                    prev = m_tdata;
                end
            end
            @(posedge clk);
        end
        @(negedge clk);
        m_tready = 1'b1;
        chk("R9", "valid low after last bin", int'(m_tvalid), 0, 0);
        chk("R9", "idle after last bin", int'(cfg_tready), 1, 0);
        chk("R9", "tlast position", last_pos, 15, 0);
        chk("R9", "tlast count", tlast_cnt, 1, 0);
    endtask

    task automatic run_case(input string tag, input int tol, input int tol0, input bit bp, input bit gaps);
        ref_dft();
        send_cfg(8'h01);
        feed(gaps, 16);
        drain(bp);
        for (int k = 0; k < 16; k++) begin
            chk(tag, $sformatf("bin%0d real", k), got_re[k], exp_re[k], (k == 0) ? tol0 : tol);
            chk(tag, $sformatf("bin%0d imag", k), got_im[k], exp_im[k], (k == 0) ? tol0 : tol);
        end
    endtask

    task automatic set_const(input int re, input int im);
        for (int n = 0; n < 16; n++) begin
            in_re[n] = re;
            in_im[n] = im;
        end
    endtask

    task automatic set_random();
        for (int n = 0; n < 16; n++) begin
            seed = seed * 32'd1103515245 + 32'd12345;
            in_re[n] = int'((seed >> 16) % 2001) - 1000;
            seed = seed * 32'd1103515245 + 32'd12345;
            in_im[n] = int'((seed >> 16) % 2001) - 1000;
        end
    endtask

    initial begin
        #400000;
        if (!done) begin
            fails++;
            $display("FAIL R9 watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        repeat (4) @(posedge clk);
        @(negedge clk);
        chk("R1", "cfg_tready in reset", int'(cfg_tready), 1, 0);
        chk("R1", "s_tready in reset", int'(s_tready), 0, 0);
        chk("R1", "m_tvalid in reset", int'(m_tvalid), 0, 0);
        rst_n = 1'b1;

        // R2: config with bit 0 clear is consumed and starts nothing
        send_cfg(8'h00);
        repeat (3) @(negedge clk);
        chk("R2", "no intake after bit0=0", int'(s_tready), 0, 0);

        // R3/R6: impulse at index 0 with both parts set, A in every bin
        set_const(0, 0);
        in_re[0] = 16'h0123;
        in_im[0] = -16'sh0456;
        run_case("R3", 3, 3, 1'b0, 1'b0);
        set_const(0, 0);
        in_re[0] = 1000;
        run_case("R6", 3, 3, 1'b0, 1'b0);

        // R5: impulse swept over every position
        for (int p = 0; p < 16; p++) begin
            set_const(0, 0);
            in_re[p] = 1000 + 37 * p;
            in_im[p] = -500 + 29 * p;
            run_case("R5", 4, 4, 1'b0, 1'b0);
        end

        // R6: constant frames, bin 0 exact
        set_const(100, 0);
        run_case("R6", 4, 0, 1'b0, 1'b0);
        set_const(-300, 0);
        run_case("R6", 4, 0, 1'b0, 1'b0);
        set_const(50, -70);
        run_case("R6", 4, 0, 1'b0, 1'b0);

        // R5: complex exponential at bin 5, real cosine at bin 3
        for (int n = 0; n < 16; n++) begin
            in_re[n] = rnd_sat(900.0 * $cos(2.0 * 3.14159265358979 * real'(5 * n) / 16.0));
            in_im[n] = rnd_sat(900.0 * $sin(2.0 * 3.14159265358979 * real'(5 * n) / 16.0));
        end
        run_case("R5", 6, 6, 1'b0, 1'b0);
        for (int n = 0; n < 16; n++) begin
            in_re[n] = rnd_sat(1000.0 * $cos(2.0 * 3.14159265358979 * real'(3 * n) / 16.0));
            in_im[n] = 0;
        end
        run_case("R5", 6, 6, 1'b0, 1'b0);

        // R10/R11: random frames with stalls on both sides, then zeros
        set_random();
        run_case("R10", 6, 6, 1'b1, 1'b1);
        set_random();
        run_case("R5", 6, 6, 1'b0, 1'b1);
        set_random();
        run_case("R10", 6, 6, 1'b1, 1'b0);
        set_const(0, 0);
        run_case("R7", 0, 0, 1'b0, 1'b0);
        set_const(0, 0);
        in_re[0] = 777;
        run_case("R11", 3, 3, 1'b0, 1'b0);

        // R8: saturation of bin 0
        set_const(4000, -3000);
        run_case("R8", 4, 0, 1'b0, 1'b0);
        set_const(-4000, 3000);
        run_case("R8", 4, 0, 1'b0, 1'b0);

        // R12: reset during intake
        set_random();
        send_cfg(8'h01);
        feed(1'b0, 5);
        rst_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        chk("R12", "idle after intake reset", int'(cfg_tready), 1, 0);
        chk("R12", "intake closed after reset", int'(s_tready), 0, 0);

        // R12: reset during output
        send_cfg(8'h01);
        feed(1'b0, 16);
        @(negedge clk);
        while (!m_tvalid) @(negedge clk);
        repeat (3) @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        chk("R12", "valid dropped by reset", int'(m_tvalid), 0, 0);
        chk("R12", "idle after output reset", int'(cfg_tready), 1, 0);
        set_random();
        run_case("R12", 6, 6, 1'b0, 1'b0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule